// File: doc/BRIEF.md
# Pending-Write Register Tracker with Writeback Bypass

This block sits in the decode stage of an in-order pipeline. It keeps one pending flag for each of 32 architectural registers. A flag marks a register whose newest value is still being produced by a long-latency unit. Only multiplies and loads are tracked. Single-cycle ALU results are covered by ordinary forwarding, and divides block the pipeline by other means.

A flag is raised when a legal multiply or load is accepted in decode with that register as its destination. It is dropped when the writeback port writes the register. A flush drops every flag at once.

In every cycle the block examines the two source operands of the instruction in decode. It reports a hit when an operand reads a register whose flag is raised. In parallel it compares each source with the writeback port. When they match, the writeback value replaces the register-file value on that operand's output. A stall is requested only when an operand hits and the writeback port cannot supply it in that same cycle.

The check runs one stage before operands are captured. All outputs are combinational functions of the current flags and inputs. The block has no data stream that needs back-pressure, so every pin is a plain level signal. The stall output is the only flow-control signal the block drives.

Top module: `reg_pending_tracker`

## Requirements
- R1: After reset no register is pending, so no source read reports a hit.
- R2: A legal instruction flagged as multiply or load raises the flag of its destination register. A legal instruction with neither flag, such as an ALU op or a divide, raises no flag.
- R3: No flag is raised in a cycle where `pipe_hold` is high or where `stall_req` is high.
- R4: When `wb_en` is high, the flag of `wb_dst` is cleared at the next clock edge.
- R5: `hit_a` (and likewise `hit_b`) is high only when that source's read enable is high, `dec_legal` is high, and the flag of the addressed register is raised.
- R6: A source is forwarded when `wb_en` is high, `wb_dst` equals the source address, the source is read, and the address is not 0. A forwarded source outputs `wb_data`. Any other source outputs its register-file data.
- R7: `stall_req` is high exactly when at least one source hits and is not forwarded.
- R8: A flush clears every flag at the next edge. Flush takes priority over any raise or clear in the same cycle.
- R9: Register 0 is never flagged, never reports a hit, and is never forwarded.
- R10: When a raise and a clear target the same register in one cycle, the register ends up flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Discard all pending flags |
| pipe_hold | input | 1 | Pipeline is stalled by another source |
| dec_legal | input | 1 | Instruction in decode is legal |
| dec_is_mul | input | 1 | Instruction in decode is a multiply |
| dec_is_load | input | 1 | Instruction in decode is a load |
| dec_dst | input | 5 | Destination register of the decoded instruction |
| src_a_rd | input | 1 | Source A is read |
| src_a_addr | input | 5 | Source A register |
| src_b_rd | input | 1 | Source B is read |
| src_b_addr | input | 5 | Source B register |
| rf_a_data | input | 32 | Register-file value for source A |
| rf_b_data | input | 32 | Register-file value for source B |
| wb_en | input | 1 | Writeback write enable |
| wb_dst | input | 5 | Writeback destination register |
| wb_data | input | 32 | Writeback value |
| hit_a | output | 1 | Source A reads a pending register |
| hit_b | output | 1 | Source B reads a pending register |
| opnd_a | output | 32 | Source A value after bypass |
| opnd_b | output | 32 | Source B value after bypass |
| stall_req | output | 1 | Hold decode: a pending source cannot be bypassed |

## Verification
Directed sequences exercise each flag transition on its own:
- a multiply or load raising a flag, next to an ALU op that must not;
- a raise held off by `pipe_hold` and, separately, by the block's own stall;
- a clear from writeback;
- a raise and a clear on the same register in one cycle;
- a flush arriving together with a raise;
- writes to register 0.

Each sequence is followed by reads that expose the resulting flag state through `hit_a` and `hit_b`. A pending read served by a matching writeback must show a hit, the bypassed data and no stall. The same read with a mismatched writeback address must stall. These two cases tell a working bypass apart from a missing or inverted one. A long random phase confines register addresses to a small range, so that collisions among the set, clear and source addresses are frequent. Every cycle of that phase is compared against a bench model of the flags.

// File: rtl/rpt_pkg.sv
package rpt_pkg;
  // Action applied to one pending flag at the next clock edge.
  typedef enum logic [1:0] {
    ACT_KEEP  = 2'd0,
    ACT_RAISE = 2'd1,
    ACT_DROP  = 2'd2,
    ACT_WIPE  = 2'd3
  } flag_act_e;
endpackage

// File: rtl/rpt_flag_table.sv
module rpt_flag_table
  import rpt_pkg::*;
#(
  parameter int NUM_REGS = 32,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                raise_en,
  input  logic [ADDR_W-1:0]   raise_addr,
  input  logic                drop_en,
  input  logic [ADDR_W-1:0]   drop_addr,
  output logic [NUM_REGS-1:0] flags
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_flag
    if (r == 0) begin : g_zero
      // Register 0 is hardwired: it can never be pending.
      assign flags[r] = 1'b0;
    end else begin : g_live
      flag_act_e act;
      logic      q;

      // Priority: flush, then raise (newer instruction), then drop.
      always_comb begin
        act = ACT_KEEP;
        if (flush) begin
          act = ACT_WIPE;
        end else if (raise_en && raise_addr == ADDR_W'(r)) begin
          act = ACT_RAISE;
        end else if (drop_en && drop_addr == ADDR_W'(r)) begin
          act = ACT_DROP;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= 1'b0;
        end else begin
          case (act)
            ACT_RAISE: q <= 1'b1;
            ACT_DROP,
            ACT_WIPE:  q <= 1'b0;
            default:   q <= q;
          endcase
        end
      end

      assign flags[r] = q;
    end
  end

  // R8: flush empties the table at the next edge
  a_r8_flush_wipes: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (flags == '0));

  // R10: a raise survives a clear of the same register
  a_r10_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_en && !flush && raise_addr != '0) |=> flags[$past(raise_addr)]);

  // R4: clear without competing raise or flush
  a_r4_drop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_en && !flush && !(raise_en && raise_addr == drop_addr))
      |=> !flags[$past(drop_addr)]);

  // R9: register 0 stays clear
  a_r9_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[0]);

endmodule

// File: rtl/rpt_operand_probe.sv
module rpt_operand_probe #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] flags,
  input  logic                legal,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   rf_data,
  input  logic                wb_en,
  input  logic [ADDR_W-1:0]   wb_dst,
  input  logic [DATA_W-1:0]   wb_data,
  output logic                hit,
  output logic                blocked,
  output logic [DATA_W-1:0]   data
);

  logic nonzero;
  logic fwd;

  assign nonzero = (addr != '0);
  assign hit     = rd_en && legal && nonzero && flags[addr];
  assign fwd     = rd_en && nonzero && wb_en && (wb_dst == addr);
  assign blocked = hit && !fwd;
  assign data    = fwd ? wb_data : rf_data;

  // R5: a hit needs a legal read of a pending register
  a_r5_hit_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (rd_en && legal && flags[addr]));

  // R9: register 0 never hits
  a_r9_zero_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> !hit);

endmodule

// File: rtl/reg_pending_tracker.sv
module reg_pending_tracker #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              pipe_hold,
  input  logic              dec_legal,
  input  logic              dec_is_mul,
  input  logic              dec_is_load,
  input  logic [ADDR_W-1:0] dec_dst,
  input  logic              src_a_rd,
  input  logic [ADDR_W-1:0] src_a_addr,
  input  logic              src_b_rd,
  input  logic [ADDR_W-1:0] src_b_addr,
  input  logic [DATA_W-1:0] rf_a_data,
  input  logic [DATA_W-1:0] rf_b_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_dst,
  input  logic [DATA_W-1:0] wb_data,
  output logic              hit_a,
  output logic              hit_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              stall_req
);

  logic [NUM_REGS-1:0] flags;
  logic                blk_a;
  logic                blk_b;
  logic                raise_en;

  // Raise only for tracked long-latency ops that actually leave decode.
  assign raise_en  = dec_legal && (dec_is_mul || dec_is_load) && !pipe_hold && !stall_req;
  assign stall_req = blk_a || blk_b;

  rpt_flag_table #(.NUM_REGS(NUM_REGS)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .raise_en   (raise_en),
    .raise_addr (dec_dst),
    .drop_en    (wb_en),
    .drop_addr  (wb_dst),
    .flags      (flags)
  );

  rpt_operand_probe #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_probe_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .legal   (dec_legal),
    .rd_en   (src_a_rd),
    .addr    (src_a_addr),
    .rf_data (rf_a_data),
    .wb_en   (wb_en),
    .wb_dst  (wb_dst),
    .wb_data (wb_data),
    .hit     (hit_a),
    .blocked (blk_a),
    .data    (opnd_a)
  );

  rpt_operand_probe #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_probe_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .legal   (dec_legal),
    .rd_en   (src_b_rd),
    .addr    (src_b_addr),
    .rf_data (rf_b_data),
    .wb_en   (wb_en),
    .wb_dst  (wb_dst),
    .wb_data (wb_data),
    .hit     (hit_b),
    .blocked (blk_b),
    .data    (opnd_b)
  );

  // R7: a stall always comes from some hit
  a_r7_stall_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (hit_a || hit_b));

  // R3: a held instruction leaves its destination flag unchanged
  a_r3_hold_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_hold && !flush && !(wb_en && wb_dst == dec_dst))
      |=> (flags[$past(dec_dst)] == $past(flags[dec_dst])));

  // R2: an untracked op leaves its destination flag unchanged
  a_r2_alu_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!dec_is_mul && !dec_is_load && !flush && !(wb_en && wb_dst == dec_dst))
      |=> (flags[$past(dec_dst)] == $past(flags[dec_dst])));

endmodule

// File: tb/sim_reg_pending_tracker.sv
module sim_reg_pending_tracker;
  localparam int NR = 32;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush, pipe_hold, dec_legal, dec_is_mul, dec_is_load;
  logic [AW-1:0] dec_dst, src_a_addr, src_b_addr, wb_dst;
  logic src_a_rd, src_b_rd, wb_en;
  logic [DW-1:0] rf_a_data, rf_b_data, wb_data;
  logic hit_a, hit_b, stall_req;
  logic [DW-1:0] opnd_a, opnd_b;

  int checks = 0;
  int failures = 0;
  logic [NR-1:0] model = '0;

  always #4 clk = ~clk;  // 125 MHz

  reg_pending_tracker #(.NUM_REGS(NR), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pipe_hold(pipe_hold),
    .dec_legal(dec_legal), .dec_is_mul(dec_is_mul), .dec_is_load(dec_is_load),
    .dec_dst(dec_dst), .src_a_rd(src_a_rd), .src_a_addr(src_a_addr),
    .src_b_rd(src_b_rd), .src_b_addr(src_b_addr), .rf_a_data(rf_a_data),
    .rf_b_data(rf_b_data), .wb_en(wb_en), .wb_dst(wb_dst), .wb_data(wb_data),
    .hit_a(hit_a), .hit_b(hit_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .stall_req(stall_req)
  );

  function automatic logic exp_hit(logic rd, logic [AW-1:0] a);
    return rd && dec_legal && (a != 0) && model[a];
  endfunction

  function automatic logic exp_fwd(logic rd, logic [AW-1:0] a);
    return rd && (a != 0) && wb_en && (wb_dst == a);
  endfunction

  task automatic chk(string tag, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    flush = 0; pipe_hold = 0; dec_legal = 0; dec_is_mul = 0; dec_is_load = 0;
    dec_dst = 0; src_a_rd = 0; src_a_addr = 0; src_b_rd = 0; src_b_addr = 0;
    rf_a_data = 32'hA0A0_0000; rf_b_data = 32'hB0B0_0000;
    wb_en = 0; wb_dst = 0; wb_data = 32'hDEAD_BEEF;
  endtask

  // Inputs are driven at the negedge; outputs checked 2 ns later, then edge.
  task automatic step(string tag);
    logic eha, ehb, efa, efb, est, raise;
    #2;
    eha = exp_hit(src_a_rd, src_a_addr);
    ehb = exp_hit(src_b_rd, src_b_addr);
    efa = exp_fwd(src_a_rd, src_a_addr);
    efb = exp_fwd(src_b_rd, src_b_addr);
    est = (eha && !efa) || (ehb && !efb);
    chk(tag, "hit_a", hit_a, eha);
    chk(tag, "hit_b", hit_b, ehb);
    chk(tag, "opnd_a", opnd_a, efa ? wb_data : rf_a_data);
    chk(tag, "opnd_b", opnd_b, efb ? wb_data : rf_b_data);
    chk(tag, "stall_req", stall_req, est);
    raise = dec_legal && (dec_is_mul || dec_is_load) && !pipe_hold && !est;
    @(posedge clk);
    if (flush) model = '0;
    else begin
      if (wb_en) model[wb_dst] = 1'b0;
      if (raise && dec_dst != 0) model[dec_dst] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic issue(logic mul, logic ld, logic [AW-1:0] d);
    dec_legal = 1; dec_is_mul = mul; dec_is_load = ld; dec_dst = d;
  endtask

  task automatic probe(logic [AW-1:0] a, string tag);
    idle(); dec_legal = 1; src_a_rd = 1; src_a_addr = a;
    step(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int seed;
    seed = $urandom(32'd20240611);
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: nothing pending after reset
    for (int r = 1; r < NR; r++) probe(AW'(r), "R1");

    // R2: multiply and load raise, ALU op does not
    idle(); issue(1, 0, 5); step("R2");
    idle(); issue(0, 1, 7); step("R2");
    idle(); issue(0, 0, 6); step("R2");
    probe(5, "R2"); probe(7, "R2"); probe(6, "R2");

    // R3: hold suppresses raise; own stall suppresses raise
    idle(); issue(1, 0, 8); pipe_hold = 1; step("R3");
    probe(8, "R3");
    idle(); issue(0, 1, 9); src_b_rd = 1; src_b_addr = 5; step("R3");
    probe(9, "R3");

    // R6 / R7: pending x7 bypassed from matching writeback, stall if mismatched
    idle(); dec_legal = 1; src_a_rd = 1; src_a_addr = 7;
    wb_en = 1; wb_dst = 7; wb_data = 32'h1234_5678; step("R6");
    issue(0, 1, 7); step("R2");  // re-raise x7
    idle(); dec_legal = 1; src_a_rd = 1; src_a_addr = 7;
    wb_en = 1; wb_dst = 4; step("R7");

    // R5: pending register not read, or instruction illegal -> no hit
    idle(); dec_legal = 0; src_a_rd = 1; src_a_addr = 5; step("R5");
    idle(); dec_legal = 1; src_a_rd = 0; src_a_addr = 5; step("R5");

    // R4: writeback clears x5
    idle(); wb_en = 1; wb_dst = 5; step("R4");
    probe(5, "R4");

    // R10: raise and clear on same register
    idle(); issue(1, 0, 10); wb_en = 1; wb_dst = 10; step("R10");
    probe(10, "R10");

    // R8: flush with a raise in the same cycle
    idle(); issue(1, 0, 11); flush = 1; step("R8");
    probe(11, "R8"); probe(7, "R8"); probe(10, "R8");

    // R9: register 0
    idle(); issue(1, 0, 0); step("R9");
    probe(0, "R9");
    idle(); dec_legal = 1; src_b_rd = 1; src_b_addr = 0;
    wb_en = 1; wb_dst = 0; step("R9");

    // Random phase: small address range for frequent collisions (R5 R6 R7)
    for (int i = 0; i < 4000; i++) begin
      idle();
      dec_legal   = ($urandom % 8) != 0;
      dec_is_mul  = ($urandom % 3) == 0;
      dec_is_load = ($urandom % 4) == 0;
      dec_dst     = AW'($urandom % 8);
      pipe_hold   = ($urandom % 6) == 0;
      src_a_rd    = $urandom % 2;
      src_b_rd    = $urandom % 2;
      src_a_addr  = AW'($urandom % 8);
      src_b_addr  = AW'($urandom % 8);
      rf_a_data   = $urandom;
      rf_b_data   = $urandom;
      wb_en       = ($urandom % 3) == 0;
      wb_dst      = AW'($urandom % 8);
      wb_data     = $urandom;
      flush       = ($urandom % 64) == 0;
      step("R7");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule